// File: doc/BRIEF.md
# Streaming Packet Generator and Checker

This block is a multi-port traffic engine that sits on the device side of a multi-channel DMA. Every port owns a receive sink that judges each arriving packet and a transmit source that produces test packets on request. Both streaming sides use a valid/ready handshake with start-of-packet and end-of-packet markers, a 64-bit beat, and an empty-bytes field that tells how many of the upper byte lanes of the final beat carry no data.

The host reaches the engine through a single-beat memory-mapped register port. It programs one packet length shared by all checkers and generators, sets a packet count per generator and starts it, reads per-port good and bad packet counters, and clears those counters. A received packet is good only when its payload is an incrementing byte pattern, its byte count equals the programmed length, and its end-of-packet marker sits on the beat that carries the last byte.

Top module: `ptg_traffic_engine`

## Requirements
- R1: After reset all good and bad counters read 0, the length register reads 4096, no transmit source is valid and every receive sink is ready.
- R2: Word address 0 holds the packet length in bytes; it reads back what was written, and a write of 0 is ignored so the previous length stays.
- R3: A received packet is good when payload byte n (counted from the start-of-packet beat, byte lane k of a beat holding byte 8*beat+k) equals n mod 256, the byte count equals the length, and end-of-packet comes on the last data beat with empty = number of unused upper lanes; unused lanes are not examined. A good packet adds 1 to the port's good counter and nothing to its bad counter.
- R4: A received packet with any payload byte off the pattern adds 1 to the bad counter and nothing to the good counter.
- R5: A packet ending with fewer or more bytes than the length, or one that reaches the length without end-of-packet, adds exactly 1 to the bad counter; beats after that point are dropped until the next start-of-packet.
- R6: A start-of-packet arriving while a packet is open counts the open packet as bad, and the new beat opens a fresh packet that is judged on its own.
- R7: Valid beats without start-of-packet while no packet is open change no counter.
- R8: Good and bad counters stop at their maximum value (2^CNT_W-1) instead of wrapping.
- R9: Per port p the register block sits at word address 16+4p: +0 control, +1 packet count, +2 good counter, +3 bad counter. Writing control bit 1 zeroes only that port's two counters; a packet verdict landing in the same cycle is counted after the clear.
- R10: Writing control bit 0 while the port is idle and its count is non-zero sends that many packets; every beat carries byte lane k = (offset+k) mod 256 on all lanes, start-of-packet on the first beat, end-of-packet on the last with empty = 8*beats - length.
- R11: While the transmit source is valid and ready is low, data and markers stay unchanged and valid stays high.
- R12: A start write while busy or with a count of 0 is ignored; control bit 0 reads 1 while the generator is busy and 0 when idle.
- R13: A read request returns its data with a one-cycle pulse on the read-valid output in the next cycle, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response pulse |
| rx_valid | input | NPORT | Receive beat valid per port |
| rx_ready | output | NPORT | Receive ready per port |
| rx_data | input | NPORT*DATA_W | Receive data, port p at bits p*DATA_W |
| rx_sop | input | NPORT | Receive start-of-packet |
| rx_eop | input | NPORT | Receive end-of-packet |
| rx_empty | input | NPORT*EMPTY_W | Unused upper lanes on the final receive beat |
| tx_valid | output | NPORT | Transmit beat valid per port |
| tx_ready | input | NPORT | Transmit ready per port |
| tx_data | output | NPORT*DATA_W | Transmit data, port p at bits p*DATA_W |
| tx_sop | output | NPORT | Transmit start-of-packet |
| tx_eop | output | NPORT | Transmit end-of-packet |
| tx_empty | output | NPORT*EMPTY_W | Unused upper lanes on the final transmit beat |

## Verification
A packet verdict and a host clear of the same port's counters can land in one cycle, as can a verdict and a read of the counter it bumps. The bench drives the clear write on exactly the cycle of a good packet's final beat and expects the counter to read 1, proving the increment was applied on top of the cleared value rather than lost or overwritten. Reads issued right after each packet show that the read path returns the settled count without a stale or doubled step.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL  = 2'd0,
    FLD_COUNT = 2'd1,
    FLD_GOOD  = 2'd2,
    FLD_BAD   = 2'd3
  } ptg_field_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int PORT_GROUP0  = 4;
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
  import ptg_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 32,
  parameter int PKT_W   = 16,
  parameter int ADDR_W  = 6,
  parameter int REG_W   = 32,
  parameter int LEN_RST = 4096
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic                         rd,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  input  logic [NPORT-1:0]             busy,
  input  logic [NPORT-1:0][CNT_W-1:0]  good_cnt,
  input  logic [NPORT-1:0][CNT_W-1:0]  bad_cnt,
  output logic [LEN_W-1:0]             len,
  output logic [NPORT-1:0][PKT_W-1:0]  pkt_count,
  output logic [NPORT-1:0]             start,
  output logic [NPORT-1:0]             clear,
  output logic [REG_W-1:0]             rdata,
  output logic                         rvalid
);
  localparam int GRP_W  = ADDR_W - 2;
  localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [GRP_W-1:0]           grp, rel;
  logic [PIDX_W-1:0]          pidx;
  ptg_field_e                 fld;
  logic                       hit_len, hit_port;
  logic [LEN_W-1:0]           len_q, len_d;
  logic [NPORT-1:0][PKT_W-1:0] cnt_q, cnt_d;
  logic [REG_W-1:0]           rdata_q, rd_mux;
  logic                       rvalid_q;
  logic [REG_W-1:0]           wdata_unused;

  assign wdata_unused = wdata;

  // address decode
  always_comb begin
    grp      = addr[ADDR_W-1:2];
    fld      = ptg_field_e'(addr[1:0]);
    rel      = grp - GRP_W'(PORT_GROUP0);
    hit_len  = (grp == '0) && (addr[1:0] == 2'd0);
    hit_port = (grp >= GRP_W'(PORT_GROUP0)) && (rel < GRP_W'(NPORT));
    pidx     = PIDX_W'(rel);
  end

  // write side: pulses and next register values
  always_comb begin
    len_d = len_q;
    if (wr && hit_len && (wdata[LEN_W-1:0] != '0))
      len_d = wdata[LEN_W-1:0];
    for (int p = 0; p < NPORT; p++) begin
      logic sel;
      sel      = hit_port && (pidx == PIDX_W'(p));
      start[p] = wr && sel && (fld == FLD_CTRL) && wdata[CTRL_RUN_BIT];
      clear[p] = wr && sel && (fld == FLD_CTRL) && wdata[CTRL_CLR_BIT];
      cnt_d[p] = (wr && sel && (fld == FLD_COUNT)) ? wdata[PKT_W-1:0] : cnt_q[p];
    end
  end

  // read side
  always_comb begin
    rd_mux = '0;
    if (hit_len) begin
      rd_mux = REG_W'(len_q);
    end else if (hit_port) begin
      unique case (fld)
        FLD_CTRL:  rd_mux = REG_W'(busy[pidx]);
        FLD_COUNT: rd_mux = REG_W'(cnt_q[pidx]);
        FLD_GOOD:  rd_mux = REG_W'(good_cnt[pidx]);
        FLD_BAD:   rd_mux = REG_W'(bad_cnt[pidx]);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= LEN_W'(LEN_RST);
      cnt_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      len_q    <= len_d;
      cnt_q    <= cnt_d;
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign len       = len_q;
  assign pkt_count = cnt_q;
  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;
endmodule

// File: rtl/ptg_rx_check.sv
module ptg_rx_check #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int EMPTY_W    = $clog2(BEAT_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [DATA_W-1:0]  data,
  input  logic               sop,
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [LEN_W-1:0]   exp_len,
  input  logic               clear,
  output logic [CNT_W-1:0]   good_cnt,
  output logic [CNT_W-1:0]   bad_cnt
);
  localparam int SEEN_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic              in_pkt_q, in_pkt_d;
  logic [SEEN_W-1:0] seen_q, seen_d, base, total, len_x;
  logic [EMPTY_W:0]  beat_bytes;
  logic              active, pat_ok, abort_prev, cur_bad, cur_good;
  logic [1:0]        bad_inc;
  logic [CNT_W-1:0]  good_q, good_d, bad_q, bad_d, good_base, bad_base;
  logic [CNT_W:0]    bad_sum;

  always_comb begin
    len_x      = {1'b0, exp_len};
    beat_bytes = eop ? ((EMPTY_W+1)'(BEAT_BYTES) - {1'b0, empty})
                     : (EMPTY_W+1)'(BEAT_BYTES);
    base       = sop ? '0 : seen_q;
    active     = valid && (sop || in_pkt_q);
    pat_ok     = 1'b1;
    for (int k = 0; k < BEAT_BYTES; k++) begin
      if (((EMPTY_W+1)'(k) < beat_bytes) &&
          (data[8*k +: 8] != 8'(base + SEEN_W'(k))))
        pat_ok = 1'b0;
    end
    total      = base + SEEN_W'(beat_bytes);
    abort_prev = valid && sop && in_pkt_q;
    cur_good   = active && eop && pat_ok && (total == len_x);
    cur_bad    = active && (eop ? !(pat_ok && (total == len_x))
                                : (!pat_ok || (total >= len_x)));
    in_pkt_d   = in_pkt_q;
    seen_d     = seen_q;
    if (active) begin
      in_pkt_d = !eop && pat_ok && (total < len_x);
      seen_d   = total;
    end
  end

  // counters: clear first, then this cycle's verdicts, saturating
  always_comb begin
    good_base = clear ? '0 : good_q;
    bad_base  = clear ? '0 : bad_q;
    good_d    = (cur_good && (good_base != CMAX)) ? good_base + 1'b1 : good_base;
    bad_inc   = {1'b0, abort_prev} + {1'b0, cur_bad};
    bad_sum   = {1'b0, bad_base} + (CNT_W+1)'(bad_inc);
    bad_d     = bad_sum[CNT_W] ? CMAX : bad_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      seen_q   <= '0;
      good_q   <= '0;
      bad_q    <= '0;
    end else begin
      if (valid) begin
        in_pkt_q <= in_pkt_d;
        seen_q   <= seen_d;
      end
      good_q <= good_d;
      bad_q  <= bad_d;
    end
  end

  assign good_cnt = good_q;
  assign bad_cnt  = bad_q;
endmodule

// File: rtl/ptg_tx_gen.sv
module ptg_tx_gen #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16,
  parameter int PKT_W  = 16,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int EMPTY_W    = $clog2(BEAT_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PKT_W-1:0]   pkt_count,
  input  logic [LEN_W-1:0]   len,
  input  logic               ready,
  output logic               valid,
  output logic [DATA_W-1:0]  data,
  output logic               sop,
  output logic               eop,
  output logic [EMPTY_W-1:0] empty,
  output logic               busy
);
  localparam int SEEN_W = LEN_W + 1;

  logic              busy_q, busy_d;
  logic [PKT_W-1:0]  left_q, left_d;
  logic [LEN_W-1:0]  off_q, off_d;
  logic [SEEN_W-1:0] tail, len_x;
  logic              step;

  always_comb begin
    len_x = {1'b0, len};
    tail  = {1'b0, off_q} + SEEN_W'(BEAT_BYTES);
    eop   = tail >= len_x;
    sop   = (off_q == '0);
    empty = eop ? EMPTY_W'(tail - len_x) : '0;
    for (int k = 0; k < BEAT_BYTES; k++)
      data[8*k +: 8] = 8'(off_q + LEN_W'(k));
  end

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    off_d  = off_q;
    step   = busy_q && ready;
    if (!busy_q) begin
      if (start && (pkt_count != '0)) begin
        busy_d = 1'b1;
        left_d = pkt_count;
        off_d  = '0;
      end
    end else if (step) begin
      if (eop) begin
        off_d  = '0;
        left_d = left_q - 1'b1;
        busy_d = (left_q != PKT_W'(1));
      end else begin
        off_d  = tail[LEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      off_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (step || !busy_q) begin
        left_q <= left_d;
        off_q  <= off_d;
      end
    end
  end

  assign valid = busy_q;
  assign busy  = busy_q;
endmodule

// File: rtl/ptg_traffic_engine.sv
module ptg_traffic_engine #(
  parameter int NPORT   = 4,
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 32,
  parameter int PKT_W   = 16,
  parameter int ADDR_W  = 6,
  parameter int REG_W   = 32,
  parameter int LEN_RST = 4096,
  localparam int EMPTY_W = $clog2(DATA_W / 8)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  output logic                      reg_rvalid,
  input  logic [NPORT-1:0]          rx_valid,
  output logic [NPORT-1:0]          rx_ready,
  input  logic [NPORT*DATA_W-1:0]   rx_data,
  input  logic [NPORT-1:0]          rx_sop,
  input  logic [NPORT-1:0]          rx_eop,
  input  logic [NPORT*EMPTY_W-1:0]  rx_empty,
  output logic [NPORT-1:0]          tx_valid,
  input  logic [NPORT-1:0]          tx_ready,
  output logic [NPORT*DATA_W-1:0]   tx_data,
  output logic [NPORT-1:0]          tx_sop,
  output logic [NPORT-1:0]          tx_eop,
  output logic [NPORT*EMPTY_W-1:0]  tx_empty
);
  logic                        rst_s0, rst_sync_n;
  logic [LEN_W-1:0]            pkt_len;
  logic [NPORT-1:0][PKT_W-1:0] pkt_count;
  logic [NPORT-1:0]            start_p, clear_p, busy_p;
  logic [NPORT-1:0][CNT_W-1:0] good_cnt, bad_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  assign rx_ready = {NPORT{rst_sync_n}};

  ptg_regs #(
    .NPORT(NPORT), .LEN_W(LEN_W), .CNT_W(CNT_W), .PKT_W(PKT_W),
    .ADDR_W(ADDR_W), .REG_W(REG_W), .LEN_RST(LEN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy_p), .good_cnt(good_cnt), .bad_cnt(bad_cnt),
    .len(pkt_len), .pkt_count(pkt_count), .start(start_p), .clear(clear_p),
    .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ptg_rx_check #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
      .clk(clk), .rst_n(rst_sync_n),
      .valid(rx_valid[p] && rst_sync_n),
      .data(rx_data[p*DATA_W +: DATA_W]),
      .sop(rx_sop[p]), .eop(rx_eop[p]),
      .empty(rx_empty[p*EMPTY_W +: EMPTY_W]),
      .exp_len(pkt_len), .clear(clear_p[p]),
      .good_cnt(good_cnt[p]), .bad_cnt(bad_cnt[p])
    );

    ptg_tx_gen #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PKT_W(PKT_W)) u_gen (
      .clk(clk), .rst_n(rst_sync_n),
      .start(start_p[p]), .pkt_count(pkt_count[p]), .len(pkt_len),
      .ready(tx_ready[p]),
      .valid(tx_valid[p]),
      .data(tx_data[p*DATA_W +: DATA_W]),
      .sop(tx_sop[p]), .eop(tx_eop[p]),
      .empty(tx_empty[p*EMPTY_W +: EMPTY_W]),
      .busy(busy_p[p])
    );
  end
endmodule

// File: rtl/ptg_traffic_engine_sva.sv
module ptg_traffic_engine_sva #(
  parameter int NPORT   = 4,
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 32,
  parameter int EMPTY_W = 3
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic                      reg_rd,
  input logic                      reg_rvalid,
  input logic [NPORT-1:0]          tx_valid,
  input logic [NPORT-1:0]          tx_ready,
  input logic [NPORT*DATA_W-1:0]   tx_data,
  input logic [NPORT-1:0]          tx_sop,
  input logic [NPORT-1:0]          tx_eop,
  input logic [NPORT*EMPTY_W-1:0]  tx_empty,
  input logic [NPORT-1:0]          start_p,
  input logic [NPORT-1:0]          clear_p,
  input logic [NPORT-1:0][CNT_W-1:0] good_cnt,
  input logic [NPORT-1:0][CNT_W-1:0] bad_cnt
);
  a_r13_read_answered: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rd |=> reg_rvalid);
  a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !reg_rd |=> !reg_rvalid);

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    a_r11_hold_beat: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (tx_valid[p] && !tx_ready[p]) |=> (tx_valid[p] &&
        $stable(tx_data[p*DATA_W +: DATA_W]) && $stable(tx_sop[p]) &&
        $stable(tx_eop[p]) && $stable(tx_empty[p*EMPTY_W +: EMPTY_W])));
    a_r10_sop_follows_eop: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (tx_valid[p] && tx_ready[p] && tx_eop[p]) |=> (!tx_valid[p] || tx_sop[p]));
    a_r12_stay_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!tx_valid[p] && !start_p[p]) |=> !tx_valid[p]);
    a_r8_good_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !clear_p[p] |=> ((good_cnt[p] == $past(good_cnt[p])) ||
                       (good_cnt[p] == $past(good_cnt[p]) + 1'b1)));
    a_r9_clear_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
      clear_p[p] |=> ((good_cnt[p] <= CNT_W'(1)) && (bad_cnt[p] <= CNT_W'(2))));
  end
endmodule

bind ptg_traffic_engine ptg_traffic_engine_sva #(
  .NPORT(NPORT), .DATA_W(DATA_W), .CNT_W(CNT_W), .EMPTY_W(EMPTY_W)
) u_sva (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_empty(tx_empty),
  .start_p(start_p), .clear_p(clear_p), .good_cnt(good_cnt), .bad_cnt(bad_cnt)
);

// File: tb/tb_ptg_traffic_engine.sv
module tb_ptg_traffic_engine;
  localparam int NP = 4;
  localparam int DW = 64;
  localparam int EW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              reg_wr, reg_rd;
  logic [5:0]        reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic              reg_rvalid;
  logic [NP-1:0]     rx_valid, rx_ready, rx_sop, rx_eop;
  logic [NP*DW-1:0]  rx_data;
  logic [NP*EW-1:0]  rx_empty;
  logic [NP-1:0]     tx_valid, tx_ready, tx_sop, tx_eop;
  logic [NP*DW-1:0]  tx_data;
  logic [NP*EW-1:0]  tx_empty;

  ptg_traffic_engine #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_empty(rx_empty),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_empty(tx_empty)
  );

  typedef struct packed {
    logic [63:0] data;
    logic        sop;
    logic        eop;
    logic [2:0]  empty;
  } beat_t;

  int          total = 0;
  int          fails = 0;
  logic [31:0] rd_expq[$];
  string       rd_tagq[$];
  beat_t       txq[$];
  int          gen_port = 1;
  int          cyc = 0;

  task automatic chk(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ready pattern for the transmit side
  initial begin
    tx_ready = '1;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = ((cyc % 3) == 1) ? '0 : '1;
    end
  end

  // monitor: pops expected reads and beats
  initial begin
    beat_t held [NP];
    bit    hold [NP];
    for (int p = 0; p < NP; p++) hold[p] = 0;
    forever begin
      @(negedge clk);
      #5;
      if (reg_rvalid) begin
        if (rd_expq.size() == 0) chk(0, "R13", "unexpected read response", 72'(reg_rdata), 0);
        else begin
          logic [31:0] e;
          string t;
          e = rd_expq.pop_front();
          t = rd_tagq.pop_front();
          chk(reg_rdata == e, t, "register read", 72'(reg_rdata), 72'(e));
        end
      end
      for (int p = 0; p < NP; p++) begin
        beat_t got;
        got = '{data: tx_data[p*DW +: DW], sop: tx_sop[p], eop: tx_eop[p],
                empty: tx_empty[p*EW +: EW]};
        if (hold[p]) chk(tx_valid[p] && (got == held[p]), "R11", "beat held while stalled",
                         72'(got), 72'(held[p]));
        if (tx_valid[p] && tx_ready[p]) begin
          if ((p != gen_port) || (txq.size() == 0))
            chk(0, "R12", "unexpected transmit beat", 72'(got), 0);
          else begin
            beat_t e;
            e = txq.pop_front();
            chk(got == e, "R10", "transmit beat", 72'(got), 72'(e));
          end
        end
        hold[p] = tx_valid[p] && !tx_ready[p];
        held[p] = got;
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] e, string tag);
    rd_expq.push_back(e);
    rd_tagq.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 6'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_pkt(int p, int nbeats, int last_empty, bit use_eop, int bad_byte,
                        bit with_sop, bit clr_last);
    for (int b = 0; b < nbeats; b++) begin
      logic [63:0] d;
      bit last;
      last = (b == nbeats - 1);
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        int n;
        n = b * 8 + k;
        d[8*k +: 8] = 8'(n);
        if (n == bad_byte) d[8*k +: 8] = d[8*k +: 8] ^ 8'h5a;
        if (last && use_eop && (k >= 8 - last_empty)) d[8*k +: 8] = 8'hee;
      end
      rx_valid[p] = 1'b1;
      rx_sop[p]   = with_sop && (b == 0);
      rx_eop[p]   = use_eop && last;
      rx_empty[p*EW +: EW] = (use_eop && last) ? 3'(last_empty) : 3'd0;
      rx_data[p*DW +: DW]  = d;
      if (clr_last && last) begin
        reg_wr = 1'b1; reg_addr = 6'(16 + 4*p); reg_wdata = 32'd2;
      end
    end
    @(negedge clk);
    rx_valid[p] = 1'b0; rx_sop[p] = 1'b0; rx_eop[p] = 1'b0;
    reg_wr = 1'b0;
  endtask

  task automatic gen_expect(int len, int npkt);
    for (int n = 0; n < npkt; n++) begin
      for (int off = 0; off < len; off += 8) begin
        beat_t e;
        for (int k = 0; k < 8; k++) e.data[8*k +: 8] = 8'(off + k);
        e.sop   = (off == 0);
        e.eop   = (off + 8 >= len);
        e.empty = e.eop ? 3'(off + 8 - len) : 3'd0;
        txq.push_back(e);
      end
    end
  endtask

  task automatic drain();
    while (txq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not end", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = '0; rx_sop = '0; rx_eop = '0; rx_empty = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(tx_valid == '0, "R1", "tx_valid after reset", 72'(tx_valid), 0);
    chk(rx_ready == '1, "R1", "rx_ready after reset", 72'(rx_ready), 72'(4'hf));
    rd(0, 32'd4096, "R1");
    for (int p = 0; p < NP; p++) begin
      rd(16 + 4*p + 2, 0, "R1");
      rd(16 + 4*p + 3, 0, "R1");
    end

    // R2 length register
    wr(0, 0);
    rd(0, 32'd4096, "R2");
    wr(0, 20);
    rd(0, 32'd20, "R2");

    // checker on port 0, length 20: three beats, last with empty 4
    rx_pkt(0, 3, 4, 1, -1, 1, 0);
    rd(18, 1, "R3"); rd(19, 0, "R3");
    rx_pkt(0, 3, 4, 1, 13, 1, 0);
    rd(18, 1, "R4"); rd(19, 1, "R4");
    rx_pkt(0, 2, 0, 1, -1, 1, 0);            // ends short
    rd(19, 2, "R5");
    rx_pkt(0, 3, 0, 0, -1, 1, 0);            // runs past length
    rd(19, 3, "R5");
    rx_pkt(0, 2, 0, 1, -1, 0, 0);            // stray beats, no sop
    rd(18, 1, "R7"); rd(19, 3, "R7");
    rx_pkt(0, 3, 0, 1, -1, 1, 0);            // 24 bytes, wrong empty
    rd(19, 4, "R5");
    rx_pkt(0, 1, 0, 0, -1, 1, 0);            // open, then new sop
    rx_pkt(0, 3, 4, 1, -1, 1, 0);
    rd(18, 2, "R6"); rd(19, 5, "R6");

    // R8 saturation on port 2
    for (int i = 0; i < 17; i++) rx_pkt(2, 3, 4, 1, -1, 1, 0);
    rd(26, 15, "R8");
    rd(18, 2, "R9 port isolation");

    // R9 clear, then clear together with a verdict
    wr(24, 2);
    rd(26, 0, "R9"); rd(27, 0, "R9");
    rd(18, 2, "R9");
    rx_pkt(2, 3, 4, 1, -1, 1, 1);
    rd(26, 1, "R9 clear with verdict");

    // R10/R11/R12 generator on port 1
    wr(21, 3);
    rd(21, 3, "R9 count readback");
    gen_expect(20, 3);
    wr(20, 1);
    wr(20, 1);                                 // ignored while busy
    rd(20, 1, "R12 busy");
    drain();
    rd(20, 0, "R12 idle");
    chk(txq.size() == 0, "R10", "all beats delivered", 72'(txq.size()), 0);

    wr(0, 8);
    wr(21, 2);
    gen_expect(8, 2);
    wr(20, 1);
    drain();
    wr(20 + 4*2, 1);                           // port 3 count is 0: ignored
    repeat (6) @(negedge clk);
    rd(28, 0, "R12 zero count");
    repeat (4) @(negedge clk);
    chk(rd_expq.size() == 0, "R13", "all reads answered", 72'(rd_expq.size()), 0);
    chk(txq.size() == 0, "R10", "queue empty at end", 72'(txq.size()), 0);
    finish_run();
  end
endmodule